// File: doc/BRIEF.md
# Shared-Clock Serial Converter Front End

This block is the device-side digital front end of an 8-bit multi-input sampling converter. It runs in the mode where one shared serial clock paces both the host transfer and the conversion. A fast local clock oversamples the shared clock, the active-low select and the serial data input. A select falling edge becomes a live transfer only after the shared clock gives two rising edges and then a falling edge. These two recognition clocks carry no address.

On the valid clocks that follow, the block shifts in an 8-bit channel code and shifts out the last conversion result on a data pin with a separate drive-enable. It also raises a sample-start strobe and a hold strobe at fixed valid falling edges. After the hold strobe, the block stays busy until an external converter reports a result. While the select is high, each shared-clock rising edge becomes a conversion tick. The converter itself, the analog mux and the sample-and-hold are outside the block, and a result input port stands in for them.

Top module: `shclk_adc_front`

## Requirements
- R1: After reset, `dout_oe`, `busy`, `sample_start`, `hold_start` and `conv_tick` are 0 and `chan_addr` is 0x00.
- R2: A select falling edge is recognised only after two `sclk` rising edges followed by a falling edge. `dout_oe` stays 0 through those two clocks, and they shift no address bit.
- R3: On each valid `sclk` rising edge, `sdin` shifts into `chan_addr` MSB first. `chan_sel` equals the code when the code is below 19 (`test_sel`=0). Otherwise `test_sel`=1 and `chan_sel`=0.
- R4: `sample_start` pulses once on the 4th valid `sclk` falling edge.
- R5: `hold_start` pulses once on the 8th valid `sclk` falling edge, and `busy` rises together with it.
- R6: While the select stays low past the 10th clock, each further `sclk` rising edge shifts another bit into `chan_addr`.
- R7: `dout` shows bit 7 of the stored result from recognition onward, and moves to the next lower bit after each valid falling edge. `dout_oe` is 1 only while a recognised transfer is live.
- R8: While the select is high and `busy` is 1, every `sclk` rising edge gives one `conv_tick` pulse. No tick occurs when not busy.
- R9: A `result_valid` pulse while busy clears `busy` and stores `result_in`. If `chan_addr` is then 19 or more, it stores 0x80 instead.
- R10: A select falling edge while busy is ignored: no output drive, no strobes, no address change.
- R11: Raising the select before the 8th valid falling edge ends the transfer with no hold strobe, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Shared serial and conversion clock |
| cs_n | input | 1 | Active-low select |
| sdin | input | 1 | Serial channel-code input |
| result_in | input | 8 | Conversion result from the external converter |
| result_valid | input | 1 | One-cycle pulse: `result_in` is ready |
| dout | output | 1 | Serial result output, MSB first |
| dout_oe | output | 1 | Drive enable for `dout`; pad floats when 0 |
| chan_addr | output | 8 | Channel code shift register |
| chan_sel | output | 5 | Decoded analog input index |
| test_sel | output | 1 | Code selects the internal test level |
| sample_start | output | 1 | One-cycle sampling-start strobe |
| hold_start | output | 1 | One-cycle hold / conversion-start strobe |
| busy | output | 1 | Conversion in progress |
| conv_tick | output | 1 | One-cycle pulse per shared-clock rise during conversion |

## Verification
Every pin edge passes two synchroniser stages and one edge-detect stage before the state update. Because of that, each strobe, address bit and `dout` change is due three to four `clk` cycles after the `sclk` edge that causes it. `busy` changes on the cycle after a `result_valid` pulse. The driver holds each `sclk` phase for eight `clk` cycles and samples `dout` and `dout_oe` only at the end of a phase, well after the change is due. The monitor takes strobes at the negative `clk` edge as they appear. It pops the expected channel code for each hold strobe from a queue filled by the driver before the transfer started.

// File: rtl/shclk_adc_front.sv
module shclk_adc_front #(
  parameter int W = 8,
  parameter int NUM_INPUTS = 19,
  parameter logic [7:0] TEST_LEVEL = 8'h80,
  parameter int SAMPLE_EDGE = 4,
  parameter int HOLD_EDGE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdin,
  input  logic [W-1:0] result_in,
  input  logic       result_valid,
  output logic       dout,
  output logic       dout_oe,
  output logic [W-1:0] chan_addr,
  output logic [$clog2(NUM_INPUTS)-1:0] chan_sel,
  output logic       test_sel,
  output logic       sample_start,
  output logic       hold_start,
  output logic       busy,
  output logic       conv_tick
);
  localparam int FW = $clog2(HOLD_EDGE + 1);
  localparam int SW = $clog2(NUM_INPUTS);

  typedef enum logic [1:0] {IDLE, RECOG, ACTIVE} st_t;
  st_t st;

  logic [2:0] sclk_sr, cs_sr, din_sr;
  logic [1:0] rcnt;
  logic [FW-1:0] fcnt;
  logic [W-1:0] oshift, result_q;

  wire rise   = sclk_sr[1] & ~sclk_sr[2];
  wire fall   = ~sclk_sr[1] & sclk_sr[2];
  wire cs_lo  = ~cs_sr[1];
  wire cs_fall = ~cs_sr[1] & cs_sr[2];

  assign dout     = oshift[W-1];
  assign dout_oe  = (st == ACTIVE);
  assign test_sel = (chan_addr >= W'(NUM_INPUTS));
  assign chan_sel = test_sel ? '0 : chan_addr[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      din_sr  <= '0;
    end else begin
      sclk_sr <= {sclk_sr[1:0], sclk};
      cs_sr   <= {cs_sr[1:0], cs_n};
      din_sr  <= {din_sr[1:0], sdin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      rcnt         <= '0;
      fcnt         <= '0;
      oshift       <= '0;
      result_q     <= '0;
      chan_addr    <= '0;
      busy         <= 1'b0;
      sample_start <= 1'b0;
      hold_start   <= 1'b0;
      conv_tick    <= 1'b0;
    end else begin
      sample_start <= 1'b0;
      hold_start   <= 1'b0;
      conv_tick    <= rise && (st == IDLE) && busy;
      if (busy && result_valid) begin
        busy     <= 1'b0;
        result_q <= test_sel ? TEST_LEVEL[W-1:0] : result_in;
      end
      case (st)
        IDLE: if (cs_fall && !busy) begin
          st   <= RECOG;
          rcnt <= '0;
        end
        RECOG: begin
          if (!cs_lo) st <= IDLE;
          else if (rise && rcnt != 2'd2) rcnt <= rcnt + 2'd1;
          else if (fall && rcnt == 2'd2) begin
            st     <= ACTIVE;
            fcnt   <= '0;
            oshift <= result_q;
          end
        end
        ACTIVE: begin
          if (!cs_lo) st <= IDLE;
          else begin
            if (rise) chan_addr <= {chan_addr[W-2:0], din_sr[1]};
            if (fall) begin
              oshift <= oshift << 1;
              if (fcnt != FW'(HOLD_EDGE)) fcnt <= fcnt + 1'b1;
              if (fcnt == FW'(SAMPLE_EDGE - 1)) sample_start <= 1'b1;
              if (fcnt == FW'(HOLD_EDGE - 1)) begin
                hold_start <= 1'b1;
                busy       <= 1'b1;
              end
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_hold_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_start |-> busy);
  p_strobes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_start && hold_start));
  p_result_clears_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && result_valid) |=> !busy);
  p_oe_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !cs_sr[2]);
  p_tick_when_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |-> (!dout_oe && busy));
  p_no_start_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == IDLE) |=> st == IDLE);
endmodule

// File: tb/shclk_adc_front_tb.sv
module shclk_adc_front_tb;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdin = 0, result_valid = 0;
  logic [7:0] result_in = 0;
  logic dout, dout_oe, test_sel, sample_start, hold_start, busy, conv_tick;
  logic [7:0] chan_addr;
  logic [4:0] chan_sel;

  int checks = 0, failures = 0, n_samp = 0, n_tick = 0, exp_samp = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  shclk_adc_front u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
    .result_in(result_in), .result_valid(result_valid), .dout(dout),
    .dout_oe(dout_oe), .chan_addr(chan_addr), .chan_sel(chan_sel),
    .test_sel(test_sel), .sample_start(sample_start), .hold_start(hold_start),
    .busy(busy), .conv_tick(conv_tick));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (sample_start) n_samp++;
    if (conv_tick) n_tick++;
    if (hold_start) begin
      if (exp_q.size() == 0) chk("R5 unexpected hold", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R3 code at hold", chan_addr, e);
        chk("R5 busy with hold", busy, 1);
      end
    end
  end

  task automatic transfer(input logic [7:0] code, input int nclk, input logic [7:0] exp_out,
                          input bit recog, input bit hold, input logic [7:0] extra);
    if (hold) exp_q.push_back(code);
    cs_n = 0;
    half();
    for (int i = 0; i < nclk; i++) begin
      if (i >= 2 && i < 10) sdin = code[9-i];
      else if (i >= 10) sdin = extra[17-i];
      else sdin = 0;
      half();
      if (i < 2) chk("R2 no drive during recognition", dout_oe, 0);
      else chk("R7 drive enable", dout_oe, recog);
      if (recog && i >= 2 && i < 10) chk("R7 serial result bit", dout, exp_out[9-i]);
      sclk = 1;
      half();
      sclk = 0;
    end
    half();
    cs_n = 1;
    half(); half();
    chk("R7 released after select", dout_oe, 0);
  endtask

  task automatic rv(input logic [7:0] v);
    @(negedge clk);
    result_in = v; result_valid = 1;
    @(negedge clk);
    result_valid = 0;
    repeat (2) @(negedge clk);
    chk("R9 busy cleared", busy, 0);
  endtask

  task automatic spin(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1; half(); sclk = 0; half();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 chan_addr", chan_addr, 0);
    chk("R1 strobes", {sample_start, hold_start, conv_tick}, 0);

    transfer(8'h05, 10, 8'h00, 1, 1, 8'h00);
    exp_samp++;
    chk("R4 sample count", n_samp, exp_samp);
    chk("R5 busy after hold", busy, 1);
    chk("R3 chan_sel", chan_sel, 5);
    chk("R3 test_sel", test_sel, 0);
    spin(4);
    chk("R8 ticks while busy", n_tick, 4);
    rv(8'h3C);
    spin(3);
    chk("R8 no tick when idle", n_tick, 4);

    transfer(8'h14, 10, 8'h3C, 1, 1, 8'h00);
    exp_samp++;
    chk("R3 test_sel for code 20", test_sel, 1);
    chk("R3 chan_sel for code 20", chan_sel, 0);
    rv(8'h55);

    transfer(8'h01, 10, 8'h80, 1, 1, 8'h00);
    exp_samp++;
    chk("R4 sample count", n_samp, exp_samp);

    transfer(8'h02, 10, 8'h00, 0, 0, 8'h00);
    chk("R10 no strobe while busy", n_samp, exp_samp);
    chk("R10 code unchanged", chan_addr, 8'h01);
    rv(8'hA7);

    transfer(8'h12, 12, 8'hA7, 1, 1, 8'h80);
    exp_samp++;
    chk("R6 extra clocks shift code", chan_addr, 8'h4A);
    rv(8'h33);

    transfer(8'h07, 7, 8'h80, 1, 0, 8'h00);
    exp_samp++;
    chk("R11 sample seen", n_samp, exp_samp);
    chk("R11 no busy after abort", busy, 0);

    transfer(8'h03, 10, 8'h80, 1, 1, 8'h00);
    exp_samp++;
    chk("R3 chan_sel", chan_sel, 3);
    rv(8'h99);
    chk("R5 all holds seen", exp_q.size(), 0);
    chk("R4 sample count", n_samp, exp_samp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule